// File: doc/BRIEF.md
# Two-stage offset min-sum check-node processor

This block does the check-node arithmetic of an iterative LDPC decoder. Each clock it can take up to sixteen incoming variable-to-check messages in sign-magnitude form. A per-slot enable lets rows of lower degree use only some of the slots. From these messages the block finds the smallest and the next-smallest magnitude, the slot that holds the smallest, and the sign of every edge together with the XOR of all of them. It then subtracts an offset from both magnitudes and clamps the result at zero.

The result leaves in two forms. The first is a compressed record: corrected minimum, corrected second minimum, winning slot, edge signs and sign product. Message memories store this record, and every outgoing message can be rebuilt from it. The second is a full set of check-to-variable messages, one per slot, ready for the variable-node side. A register between the two half-tree searches and the merge step splits the datapath into two balanced stages. Two frames can therefore be interleaved with a new input accepted on every cycle.

Top module: `msum_check_unit`

## Requirements
- R1: A vector presented with `in_valid` high at clock edge k produces `out_valid` high after edge k+2. A cycle with `in_valid` low produces `out_valid` low two edges later.
- R2: An input magnitude above 2^W_MAG-1 (15 by default) is treated as 15 before any comparison.
- R3: A slot whose enable bit is 0 behaves as a positive input of magnitude 15, whatever its sign and magnitude inputs carry.
- R4: `out_min1` is the smallest of the sixteen conditioned magnitudes, and `out_min2` is the smallest of the remaining fifteen. A duplicate of the minimum counts. Both values are reduced by OFFSET (1 by default).
- R5: `out_idx` is the lowest-numbered slot whose conditioned magnitude equals the minimum.
- R6: `out_edge_sign[i]` equals `in_sign[i] & in_en[i]`, and `out_parity` is the XOR of all sixteen of those bits.
- R7: The expanded message of slot i has sign `out_parity ^ out_edge_sign[i]`. Its magnitude, held in bits [4i+3:4i] of `out_msg_mag`, is `out_min2` when i equals `out_idx` and `out_min1` otherwise.
- R8: While `rst_n` is low, `out_valid` and every output field read zero.
- R9: Vectors presented on consecutive cycles each produce a result, in order, on consecutive cycles, with no idle cycle inserted.
- R10: A magnitude at or below OFFSET becomes 0 after correction and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector present |
| in_en | input | N_IN | Per-slot enable |
| in_sign | input | N_IN | Per-slot sign bit, 1 = negative |
| in_mag | input | N_IN*W_IN | Per-slot magnitude, slot i in bits [W_IN*i +: W_IN] |
| out_valid | output | 1 | Result present |
| out_min1 | output | W_MAG | Corrected smallest magnitude |
| out_min2 | output | W_MAG | Corrected second-smallest magnitude |
| out_idx | output | log2(N_IN) | Slot of the smallest magnitude |
| out_edge_sign | output | N_IN | Masked input signs |
| out_parity | output | 1 | XOR of the masked signs |
| out_msg_sign | output | N_IN | Sign of each outgoing message |
| out_msg_mag | output | N_IN*W_MAG | Magnitude of each outgoing message |

## Verification
The bench builds the block at its default parameters: sixteen slots, 6-bit input magnitudes, 4-bit internal magnitudes and an offset of 1. Sixteen slots exercise both half-trees and the merge across them. The 6-bit inputs reach the saturation path, and the offset of 1 makes clamping reachable from inputs of 0 and 1. Directed vectors cover all slots disabled, full ties, duplicated zeros, a winner in the last slot and a disabled slot carrying a would-be minimum. Several thousand further vectors mix enable densities, large and small magnitudes, and back-to-back and gapped issue.

// File: rtl/msum_check_unit.sv
module msum_check_unit #(
  parameter int N_IN   = 16,
  parameter int W_IN   = 6,
  parameter int W_MAG  = 4,
  parameter int OFFSET = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [N_IN-1:0]           in_en,
  input  logic [N_IN-1:0]           in_sign,
  input  logic [N_IN*W_IN-1:0]      in_mag,
  output logic                      out_valid,
  output logic [W_MAG-1:0]          out_min1,
  output logic [W_MAG-1:0]          out_min2,
  output logic [$clog2(N_IN)-1:0]   out_idx,
  output logic [N_IN-1:0]           out_edge_sign,
  output logic                      out_parity,
  output logic [N_IN-1:0]           out_msg_sign,
  output logic [N_IN*W_MAG-1:0]     out_msg_mag
);
  localparam int HALF = N_IN / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int IW   = $clog2(N_IN);
  localparam logic [W_MAG-1:0] MAXV = '1;

  function automatic logic [W_MAG-1:0] sub_off(input logic [W_MAG-1:0] x);
    return (x > W_MAG'(OFFSET)) ? x - W_MAG'(OFFSET) : '0;
  endfunction

  // input conditioning: saturate, mask disabled slots
  logic [W_MAG-1:0] sat [N_IN];
  logic [N_IN-1:0]  sgn;
  assign sgn = in_sign & in_en;

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_sat
    wire [W_IN-1:0] raw = in_mag[gi*W_IN +: W_IN];
    assign sat[gi] = !in_en[gi]            ? MAXV :
                     (raw > W_IN'(MAXV))   ? MAXV : raw[W_MAG-1:0];
  end

  // stage 1: two half searches, lowest index wins ties
  for (genvar gh = 0; gh < 2; gh++) begin : g_half
    logic [W_MAG-1:0] m1, m2;
    logic [HW-1:0]    ix;
    always_comb begin
      m1 = MAXV;
      m2 = MAXV;
      ix = '0;
      for (int j = 0; j < HALF; j++) begin
        if (sat[gh*HALF+j] < m1) begin
          m2 = m1;
          m1 = sat[gh*HALF+j];
          ix = HW'(j);
        end else if (sat[gh*HALF+j] < m2) begin
          m2 = sat[gh*HALF+j];
        end
      end
    end
  end

  logic             s1_valid, s1_par;
  logic [N_IN-1:0]  s1_sgn;
  logic [W_MAG-1:0] s1_a_m1, s1_a_m2, s1_b_m1, s1_b_m2;
  logic [HW-1:0]    s1_a_ix, s1_b_ix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_par   <= 1'b0;
      s1_sgn   <= '0;
      s1_a_m1  <= '0;
      s1_a_m2  <= '0;
      s1_b_m1  <= '0;
      s1_b_m2  <= '0;
      s1_a_ix  <= '0;
      s1_b_ix  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_par   <= ^sgn;
      s1_sgn   <= sgn;
      s1_a_m1  <= g_half[0].m1;
      s1_a_m2  <= g_half[0].m2;
      s1_a_ix  <= g_half[0].ix;
      s1_b_m1  <= g_half[1].m1;
      s1_b_m2  <= g_half[1].m2;
      s1_b_ix  <= g_half[1].ix;
    end
  end

  // stage 2: merge halves, correct, expand
  logic             b_wins;
  logic [W_MAG-1:0] mg_m1, mg_m2, c1, c2;
  logic [IW-1:0]    mg_ix;
  logic [N_IN*W_MAG-1:0] nx_mag;

  assign b_wins = s1_b_m1 < s1_a_m1;
  assign mg_m1  = b_wins ? s1_b_m1 : s1_a_m1;
  assign mg_ix  = b_wins ? {1'b1, s1_b_ix} : {1'b0, s1_a_ix};
  assign mg_m2  = b_wins ? ((s1_a_m1 < s1_b_m2) ? s1_a_m1 : s1_b_m2)
                         : ((s1_b_m1 < s1_a_m2) ? s1_b_m1 : s1_a_m2);
  assign c1 = sub_off(mg_m1);
  assign c2 = sub_off(mg_m2);

  for (genvar ge = 0; ge < N_IN; ge++) begin : g_exp
    assign nx_mag[ge*W_MAG +: W_MAG] = (mg_ix == IW'(ge)) ? c2 : c1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_min1      <= '0;
      out_min2      <= '0;
      out_idx       <= '0;
      out_edge_sign <= '0;
      out_parity    <= 1'b0;
      out_msg_sign  <= '0;
      out_msg_mag   <= '0;
    end else begin
      out_valid     <= s1_valid;
      out_min1      <= c1;
      out_min2      <= c2;
      out_idx       <= mg_ix;
      out_edge_sign <= s1_sgn;
      out_parity    <= s1_par;
      out_msg_sign  <= s1_sgn ^ {N_IN{s1_par}};
      out_msg_mag   <= nx_mag;
    end
  end
endmodule

module msum_check_unit_chk #(
  parameter int N_IN   = 16,
  parameter int W_MAG  = 4,
  parameter int OFFSET = 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [N_IN-1:0]         in_en,
  input logic [N_IN-1:0]         in_sign,
  input logic                    out_valid,
  input logic [W_MAG-1:0]        out_min1,
  input logic [W_MAG-1:0]        out_min2,
  input logic [$clog2(N_IN)-1:0] out_idx,
  input logic [N_IN-1:0]         out_edge_sign,
  input logic                    out_parity,
  input logic [N_IN*W_MAG-1:0]   out_msg_mag
);
  localparam int LIM = (1 << W_MAG) - 1 - OFFSET;

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  // R1
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  // R4
  min_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_min1 <= out_min2);
  // R10
  clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_min2) <= LIM));
  // R6
  edge_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_edge_sign == $past(in_sign & in_en, 2));
  // R6
  parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_parity == $past(^(in_sign & in_en), 2));
  // R7
  msg_min2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> W_MAG'(out_msg_mag >> (int'(out_idx) * W_MAG)) == out_min2);
endmodule

bind msum_check_unit msum_check_unit_chk #(
  .N_IN(N_IN), .W_MAG(W_MAG), .OFFSET(OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_en(in_en),
  .in_sign(in_sign), .out_valid(out_valid), .out_min1(out_min1),
  .out_min2(out_min2), .out_idx(out_idx), .out_edge_sign(out_edge_sign),
  .out_parity(out_parity), .out_msg_mag(out_msg_mag)
);

// File: tb/msum_check_unit_tb.sv
`timescale 1ns/1ps
module msum_check_unit_tb_top;
  localparam int N   = 16;
  localparam int WI  = 6;
  localparam int WM  = 4;
  localparam int OFF = 1;
  localparam int MX  = 15;
  localparam int DEPTH = 4096;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [N-1:0] in_en = '0, in_sign = '0;
  logic [N*WI-1:0] in_mag = '0;
  logic out_valid, out_parity;
  logic [WM-1:0] out_min1, out_min2;
  logic [3:0] out_idx;
  logic [N-1:0] out_edge_sign, out_msg_sign;
  logic [N*WM-1:0] out_msg_mag;

  msum_check_unit #(.N_IN(N), .W_IN(WI), .W_MAG(WM), .OFFSET(OFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_en(in_en),
    .in_sign(in_sign), .in_mag(in_mag), .out_valid(out_valid),
    .out_min1(out_min1), .out_min2(out_min2), .out_idx(out_idx),
    .out_edge_sign(out_edge_sign), .out_parity(out_parity),
    .out_msg_sign(out_msg_sign), .out_msg_mag(out_msg_mag));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0, wr = 0, rd = 0;
  int e_m1 [DEPTH], e_m2 [DEPTH], e_ix [DEPTH], e_cyc [DEPTH];
  logic [N-1:0] e_es [DEPTH];
  logic e_par [DEPTH];
  logic done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (vector %0d)", tag, act, exp, rd);
    end
  endtask

  function automatic int corr(input int x);
    return (x > OFF) ? x - OFF : 0;
  endfunction

  task automatic issue(input logic [N-1:0] en, input logic [N-1:0] sg,
                       input logic [N*WI-1:0] mg);
    int m [N];
    int mn1, mn2, ix;
    @(negedge clk);
    in_valid = 1; in_en = en; in_sign = sg; in_mag = mg;
    for (int i = 0; i < N; i++) begin
      int v = int'(mg[i*WI +: WI]);
      m[i] = !en[i] ? MX : (v > MX ? MX : v);
    end
    mn1 = MX;
    for (int i = 0; i < N; i++) if (m[i] < mn1) mn1 = m[i];
    ix = -1;
    for (int i = N-1; i >= 0; i--) if (m[i] == mn1) ix = i;
    mn2 = MX;
    for (int i = 0; i < N; i++) if (i != ix && m[i] < mn2) mn2 = m[i];
    e_m1[wr] = corr(mn1); e_m2[wr] = corr(mn2); e_ix[wr] = ix;
    e_es[wr] = sg & en; e_par[wr] = ^(sg & en); e_cyc[wr] = cyc;
    wr++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [N*WI-1:0] fill(input int v);
    logic [N*WI-1:0] r;
    for (int i = 0; i < N; i++) r[i*WI +: WI] = WI'(v);
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd >= wr) begin
        chk("R1 spurious out_valid", 1, 0);
      end else begin
        chk("R1 R9 latency", cyc - e_cyc[rd], 2);
        chk("R4 R2 R3 R10 min1", out_min1, e_m1[rd]);
        chk("R4 R2 R3 R10 min2", out_min2, e_m2[rd]);
        chk("R5 idx", out_idx, e_ix[rd]);
        chk("R6 edge signs", out_edge_sign, e_es[rd]);
        chk("R6 parity", out_parity, e_par[rd]);
        for (int i = 0; i < N; i++) begin
          chk("R7 msg sign", out_msg_sign[i], e_par[rd] ^ e_es[rd][i]);
          chk("R7 msg mag", out_msg_mag[i*WM +: WM],
              (i == e_ix[rd]) ? e_m2[rd] : e_m1[rd]);
        end
        rd++;
      end
    end
  end

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [N*WI-1:0] mg;
    repeat (3) @(negedge clk);
    // R8
    chk("R8 reset valid", out_valid, 0);
    chk("R8 reset min1", out_min1, 0);
    chk("R8 reset msgs", out_msg_mag, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R8 idle after reset", out_valid, 0);

    // R3 all disabled
    issue('0, '1, fill(0));
    // R2 saturation: all oversized
    issue('1, 16'h00F0, fill(40));
    // R5 full tie
    issue('1, 16'h1234, fill(3));
    // R10 clamp: winner in last slot at 0, others 1
    mg = fill(1); mg[15*WI +: WI] = 0;
    issue('1, 16'h8001, mg);
    // R5 duplicate zeros in slots 5 and 9
    mg = fill(12); mg[5*WI +: WI] = 0; mg[9*WI +: WI] = 0;
    issue('1, 16'h0220, mg);
    // R3 disabled slot holds would-be minimum and negative sign
    mg = fill(9); mg[2*WI +: WI] = 0;
    issue(16'hFFFB, 16'h0004, mg);
    // R2 oversized next to in-range
    mg = fill(63); mg[7*WI +: WI] = 14; mg[8*WI +: WI] = 20;
    issue('1, '0, mg);
    // R4 minimum crossing halves
    mg = fill(10); mg[3*WI +: WI] = 6; mg[12*WI +: WI] = 4;
    issue('1, 16'hFFFF, mg);
    idle(); idle();
    // R9 back-to-back random stream with occasional gaps
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] en, sg;
      logic [N*WI-1:0] r;
      case (k % 4)
        0: en = '1;
        1: en = N'($urandom);
        2: en = N'($urandom) & N'($urandom);
        default: en = N'($urandom) | N'($urandom);
      endcase
      sg = N'($urandom);
      for (int i = 0; i < N; i++)
        r[i*WI +: WI] = (k % 3 == 0) ? WI'($urandom % 64) : WI'($urandom % 8);
      issue(en, sg, r);
      if ($urandom % 5 == 0) idle();
    end
    idle();
    repeat (6) @(negedge clk);
    chk("R9 result count", rd, wr);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule